// File: doc/BRIEF.md
# Masked Priority Interrupt Register

This block records interrupt arrivals on 27 levels and names the single level that should be serviced next. The levels are a machine-check level, 24 device levels numbered 0 to 23, a trace level and a maintenance level. Device levels can be inhibited one at a time by a mask. A global disable holds off every level, including the three fixed ones. Devices are sampled over a shared polled bus that carries one of two level groups at a time. Software can also raise device levels directly with a program-interrupt write.

Each level keeps three state bits. The level bit records that an event arrived. The request bit asks the controller for a forced branch. An acknowledge bit stops the same event from being requested twice. The controller uses the clear-request pulse once the forced branch has been taken. It uses the clear-level pulse when the service routine exits, and both pulses act on the level named by `clr_idx`. A level that is being serviced keeps blocking every lower level until its level bit is cleared, so nesting happens only from higher priority.

Top module: `irq_prio_reg`

## Requirements
- R1: Levels occupy slots 0 to 26. Machine check is slot 0, device level n is slot n+1, trace is slot 25 and maintenance is slot 26, and a lower slot has higher priority. `act_onehot` has exactly the bit of the highest-priority recorded level (or no bit), and `act_idx` gives that slot number.
- R2: After reset all 24 mask bits are 1 (inhibit) and every level, request and acknowledge bit is 0, so `act_onehot` is 0 and `any_int` is 0.
- R3: With `poll_set` high, `poll_grp`=0 records `poll_bus` bit i (i = 0..13) into device level i, and `poll_grp`=1 records bit j (j = 0..9) into device level 14+j. The level shows on `act_onehot`/`act_idx` in the cycle after the edge that samples `poll_set`.
- R4: A device level whose mask bit is 1 is not recorded by a poll. Clearing the mask later does not bring the lost event back.
- R5: `mask_wr` replaces the whole mask with `mask_data`, where bit n is the mask of device level n. Bits that were set before and are 0 in the new data become clear.
- R6: `sys_req` bit 0 records machine check, bit 1 records trace and bit 2 records maintenance in any cycle, and the mask has no effect on them.
- R7: With `prog_wr` high, `prog_hi`=0 sets device levels 0..13 from `prog_data` bits 0..13, and `prog_hi`=1 sets device levels 14..23 from bits 0..9. The mask is ignored, and bits 10..13 have no effect when `prog_hi`=1.
- R8: While `disable_all` is 1, `act_onehot` is 0 and `any_int` is 0, but arrivals are still recorded. When it returns to 0, the highest recorded level appears at once and `any_int` rises one cycle later.
- R9: A level becomes requested one clock after its level bit is seen with disable off. `any_int` is 1 when the active level has its request bit set.
- R10: `clr_req` with `clr_idx` naming a level clears that level's request. The level stays active and keeps lower levels blocked, and `any_int` is 0 from the next cycle.
- R11: `clr_lvl` with `clr_idx` clears that level's level and request bits. The next recorded level becomes active in the following cycle, and it is requested at once if its request is already pending.
- R12: Once its request has been cleared, a level is not requested again until its level bit has been cleared and then set by a new arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poll_set | input | 1 | Sample strobe for the polled bus |
| poll_grp | input | 1 | Polled group: 0 = device levels 0..13, 1 = device levels 14..23 |
| poll_bus | input | 14 | Polled request bits for the selected group |
| mask_wr | input | 1 | Mask replace strobe |
| mask_data | input | 24 | New mask, 1 inhibits the device level |
| prog_wr | input | 1 | Program-interrupt strobe |
| prog_hi | input | 1 | Program-interrupt group: 0 = levels 0..13, 1 = levels 14..23 |
| prog_data | input | 14 | Program-interrupt bits for the selected group |
| sys_req | input | 3 | Fixed-level arrivals: bit 0 check, bit 1 trace, bit 2 maintenance |
| disable_all | input | 1 | Global hold-off of every level |
| clr_req | input | 1 | Clear the request bit of level `clr_idx` |
| clr_lvl | input | 1 | Clear the level bit of level `clr_idx` |
| clr_idx | input | 5 | Slot number of the serviced level |
| any_int | output | 1 | Active level has an outstanding request |
| act_onehot | output | 27 | One-hot highest-priority active level |
| act_idx | output | 5 | Slot number of the active level |

## Verification
The bench builds the block with its default parameters: 24 maskable levels, 14 of them in the first polled group, which gives a 14-bit bus and 27 slots. With these values it reaches both group edges (bus bit 13 in the first group and bit 9 in the second). It also reaches the three fixed slots at 0, 25 and 26, and it drives the high bus bits that must be ignored in the second group. A table walks poll and mask combinations. Directed runs then follow one service nesting from request through acknowledge to level clear, and they toggle the global disable around a recorded arrival.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int unsigned DEF_MASKED = 24;
    localparam int unsigned DEF_GRP_A  = 14;
    localparam int unsigned N_FIXED    = 3;

    typedef enum logic [1:0] {
        FIX_CHECK = 2'd0,
        FIX_TRACE = 2'd1,
        FIX_MAINT = 2'd2
    } fixed_src_e;

    typedef struct packed {
        logic poll_lo;
        logic poll_hi;
        logic prog_lo;
        logic prog_hi;
    } grp_strobe_t;

    function automatic grp_strobe_t decode_strobes(logic p_set, logic p_grp,
                                                   logic g_wr, logic g_hi);
        grp_strobe_t s;
        s.poll_lo = p_set & ~p_grp;
        s.poll_hi = p_set &  p_grp;
        s.prog_lo = g_wr  & ~g_hi;
        s.prog_hi = g_wr  &  g_hi;
        return s;
    endfunction

endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] mask
);

    // A write clears all bits and then sets the given ones: net effect is a replace.
    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '1;
        end else if (wr_en) begin
            mask <= wr_data;
        end
    end

endmodule

// File: rtl/irq_level_bank.sv
module irq_level_bank #(
    parameter int unsigned NLVL = 27
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NLVL-1:0] set_vec,
    input  logic [NLVL-1:0] clr_req_vec,
    input  logic [NLVL-1:0] clr_lvl_vec,
    input  logic            disable_all,
    output logic [NLVL-1:0] lvl_q,
    output logic [NLVL-1:0] req_q
);

    logic [NLVL-1:0] ack_q;

    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        // Arrival wins over a clear in the same cycle.
        always_ff @(posedge clk) begin
            if (rst) begin
                lvl_q[g] <= 1'b0;
                ack_q[g] <= 1'b0;
                req_q[g] <= 1'b0;
            end else begin
                lvl_q[g] <= (lvl_q[g] & ~clr_lvl_vec[g]) | set_vec[g];
                ack_q[g] <= (ack_q[g] | clr_req_vec[g]) & ~clr_lvl_vec[g];
                if (clr_req_vec[g] || clr_lvl_vec[g]) begin
                    req_q[g] <= 1'b0;
                end else if (lvl_q[g] && !disable_all && !ack_q[g]) begin
                    req_q[g] <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int unsigned NLVL  = 27,
    parameter int unsigned IDX_W = 5
) (
    input  logic [NLVL-1:0]  lvl,
    input  logic             disable_all,
    output logic [NLVL-1:0]  act_oh,
    output logic [IDX_W-1:0] act_idx
);

    logic [NLVL-1:0] ok;
    logic [NLVL-1:0] above;

    for (genvar g = 0; g < NLVL; g++) begin : g_chain
        assign ok[g] = lvl[g] & ~disable_all;
        if (g == 0) begin : g_top
            assign above[g] = 1'b0;
        end else begin : g_rest
            assign above[g] = above[g-1] | ok[g-1];
        end
        assign act_oh[g] = ok[g] & ~above[g];
    end

    always_comb begin
        act_idx = '0;
        for (int i = 0; i < NLVL; i++) begin
            if (act_oh[i]) begin
                act_idx = act_idx | IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_prio_reg.sv
module irq_prio_reg
    import irq_prio_pkg::*;
#(
    parameter  int unsigned MASKED_LVLS = DEF_MASKED,
    parameter  int unsigned GRP_A_LVLS  = DEF_GRP_A,
    localparam int unsigned GRP_B_LVLS  = MASKED_LVLS - GRP_A_LVLS,
    localparam int unsigned BUS_W       = (GRP_A_LVLS > GRP_B_LVLS) ? GRP_A_LVLS : GRP_B_LVLS,
    localparam int unsigned NLVL        = MASKED_LVLS + N_FIXED,
    localparam int unsigned IDX_W       = $clog2(NLVL)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   poll_set,
    input  logic                   poll_grp,
    input  logic [BUS_W-1:0]       poll_bus,
    input  logic                   mask_wr,
    input  logic [MASKED_LVLS-1:0] mask_data,
    input  logic                   prog_wr,
    input  logic                   prog_hi,
    input  logic [BUS_W-1:0]       prog_data,
    input  logic [N_FIXED-1:0]     sys_req,
    input  logic                   disable_all,
    input  logic                   clr_req,
    input  logic                   clr_lvl,
    input  logic [IDX_W-1:0]       clr_idx,
    output logic                   any_int,
    output logic [NLVL-1:0]        act_onehot,
    output logic [IDX_W-1:0]       act_idx
);

    localparam int unsigned SLOT_CHECK = 0;
    localparam int unsigned SLOT_TRACE = NLVL - 2;
    localparam int unsigned SLOT_MAINT = NLVL - 1;
    localparam int unsigned SLOT_DEV0  = 1;

    logic [MASKED_LVLS-1:0] mask_q;
    logic [NLVL-1:0]        set_vec;
    logic [NLVL-1:0]        clr_req_vec;
    logic [NLVL-1:0]        clr_lvl_vec;
    logic [NLVL-1:0]        lvl_q;
    logic [NLVL-1:0]        req_q;
    logic [NLVL-1:0]        act_oh;
    grp_strobe_t            stb;

    assign stb = decode_strobes(poll_set, poll_grp, prog_wr, prog_hi);

    irq_mask_reg #(.W(MASKED_LVLS)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mask_wr),
        .wr_data (mask_data),
        .mask    (mask_q)
    );

    // Polled sets pass the mask; program sets bypass it.
    for (genvar a = 0; a < GRP_A_LVLS; a++) begin : g_grp_a
        assign set_vec[SLOT_DEV0 + a] = (stb.poll_lo & poll_bus[a] & ~mask_q[a])
                                      | (stb.prog_lo & prog_data[a]);
    end

    for (genvar b = 0; b < GRP_B_LVLS; b++) begin : g_grp_b
        assign set_vec[SLOT_DEV0 + GRP_A_LVLS + b] =
              (stb.poll_hi & poll_bus[b] & ~mask_q[GRP_A_LVLS + b])
            | (stb.prog_hi & prog_data[b]);
    end

    assign set_vec[SLOT_CHECK] = sys_req[FIX_CHECK];
    assign set_vec[SLOT_TRACE] = sys_req[FIX_TRACE];
    assign set_vec[SLOT_MAINT] = sys_req[FIX_MAINT];

    for (genvar c = 0; c < NLVL; c++) begin : g_clr
        assign clr_req_vec[c] = clr_req & (clr_idx == IDX_W'(c));
        assign clr_lvl_vec[c] = clr_lvl & (clr_idx == IDX_W'(c));
    end

    irq_level_bank #(.NLVL(NLVL)) u_bank (
        .clk         (clk),
        .rst         (rst),
        .set_vec     (set_vec),
        .clr_req_vec (clr_req_vec),
        .clr_lvl_vec (clr_lvl_vec),
        .disable_all (disable_all),
        .lvl_q       (lvl_q),
        .req_q       (req_q)
    );

    irq_prio_pick #(.NLVL(NLVL), .IDX_W(IDX_W)) u_pick (
        .lvl         (lvl_q),
        .disable_all (disable_all),
        .act_oh      (act_oh),
        .act_idx     (act_idx)
    );

    assign act_onehot = act_oh;
    assign any_int    = |(act_oh & req_q);

endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
    import irq_prio_pkg::*;
#(
    parameter int unsigned NLVL  = 27,
    parameter int unsigned IDX_W = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               poll_set,
    input logic               poll_grp,
    input logic               poll_bit0,
    input logic               mask_bit0,
    input logic               prog_wr,
    input logic [N_FIXED-1:0] sys_req,
    input logic               disable_all,
    input logic               clr_req,
    input logic               clr_lvl,
    input logic [IDX_W-1:0]   clr_idx,
    input logic               lvl_dev0,
    input logic               any_int,
    input logic [NLVL-1:0]    act_onehot,
    input logic [IDX_W-1:0]   act_idx
);

    logic quiet;
    assign quiet = !poll_set && !prog_wr && (sys_req == '0);

    // R2
    post_reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (act_onehot == '0) && !any_int);

    // R1
    single_active_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(act_onehot));

    // R8
    disable_hold_chk: assert property (@(posedge clk) disable iff (rst)
        disable_all |-> (act_onehot == '0) && !any_int);

    // R4
    masked_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (poll_set && !poll_grp && poll_bit0 && mask_bit0 && !prog_wr && !lvl_dev0)
        |=> !lvl_dev0);

    // R10
    req_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !clr_lvl && quiet && (act_onehot != '0) && (clr_idx == act_idx))
        |=> !any_int);

    // R11
    level_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_lvl && quiet && (act_onehot != '0) && (clr_idx == act_idx))
        |=> (act_onehot != $past(act_onehot)));

endmodule

bind irq_prio_reg irq_prio_chk #(.NLVL(NLVL), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .poll_set    (poll_set),
    .poll_grp    (poll_grp),
    .poll_bit0   (poll_bus[0]),
    .mask_bit0   (mask_q[0]),
    .prog_wr     (prog_wr),
    .sys_req     (sys_req),
    .disable_all (disable_all),
    .clr_req     (clr_req),
    .clr_lvl     (clr_lvl),
    .clr_idx     (clr_idx),
    .lvl_dev0    (lvl_q[1]),
    .any_int     (any_int),
    .act_onehot  (act_onehot),
    .act_idx     (act_idx)
);

// File: tb/irq_prio_reg_test.sv
`timescale 1ns/1ps
module irq_prio_reg_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        poll_set, poll_grp, mask_wr, prog_wr, prog_hi;
    logic [13:0] poll_bus, prog_data;
    logic [23:0] mask_data;
    logic [2:0]  sys_req;
    logic        disable_all, clr_req, clr_lvl;
    logic [4:0]  clr_idx;
    logic        any_int;
    logic [26:0] act_onehot;
    logic [4:0]  act_idx;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_prio_reg uut (
        .clk(clk), .rst(rst), .poll_set(poll_set), .poll_grp(poll_grp),
        .poll_bus(poll_bus), .mask_wr(mask_wr), .mask_data(mask_data),
        .prog_wr(prog_wr), .prog_hi(prog_hi), .prog_data(prog_data),
        .sys_req(sys_req), .disable_all(disable_all), .clr_req(clr_req),
        .clr_lvl(clr_lvl), .clr_idx(clr_idx), .any_int(any_int),
        .act_onehot(act_onehot), .act_idx(act_idx)
    );

    typedef struct packed {
        logic        grp;
        logic [13:0] bus;
        logic [23:0] mask;
        logic        hit;
        logic [4:0]  idx;
    } row_t;

    localparam row_t ROWS [8] = '{
        '{1'b0, 14'h0001, 24'h000000, 1'b1, 5'd1},
        '{1'b0, 14'h2000, 24'h000000, 1'b1, 5'd14},
        '{1'b1, 14'h0001, 24'h000000, 1'b1, 5'd15},
        '{1'b1, 14'h0200, 24'h000000, 1'b1, 5'd24},
        '{1'b0, 14'h0014, 24'h000000, 1'b1, 5'd3},
        '{1'b0, 14'h0014, 24'h000004, 1'b1, 5'd5},
        '{1'b0, 14'h3FFF, 24'hFFFFFF, 1'b0, 5'd0},
        '{1'b1, 14'h3C00, 24'h000000, 1'b0, 5'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; poll_set = 0; poll_grp = 0; poll_bus = '0; mask_wr = 0;
        mask_data = '0; prog_wr = 0; prog_hi = 0; prog_data = '0; sys_req = '0;
        disable_all = 0; clr_req = 0; clr_lvl = 0; clr_idx = '0;
        step(); step();
        rst = 1'b0;
    endtask

    task automatic poll(input logic g, input logic [13:0] b);
        poll_set = 1'b1; poll_grp = g; poll_bus = b;
        step();
        poll_set = 1'b0; poll_bus = '0;
    endtask

    task automatic wmask(input logic [23:0] m);
        mask_wr = 1'b1; mask_data = m;
        step();
        mask_wr = 1'b0;
    endtask

    task automatic prog(input logic h, input logic [13:0] d);
        prog_wr = 1'b1; prog_hi = h; prog_data = d;
        step();
        prog_wr = 1'b0; prog_data = '0;
    endtask

    task automatic sysp(input logic [2:0] s);
        sys_req = s;
        step();
        sys_req = '0;
    endtask

    task automatic clrq(input logic [4:0] i);
        clr_req = 1'b1; clr_idx = i;
        step();
        clr_req = 1'b0;
    endtask

    task automatic clrl(input logic [4:0] i);
        clr_lvl = 1'b1; clr_idx = i;
        step();
        clr_lvl = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        // R2: reset state and reset mask
        do_reset();
        chk("R2 onehot after reset", 32'(act_onehot), 32'h0);
        chk("R2 any_int after reset", 32'(any_int), 32'h0);
        poll(1'b0, 14'h3FFF);
        chk("R2 masks set after reset", 32'(act_onehot), 32'h0);
        wmask(24'h000000);
        chk("R4 masked arrival not kept", 32'(act_onehot), 32'h0);

        // R1 R3 R4 R5: table walk
        for (int r = 0; r < 8; r++) begin
            do_reset();
            wmask(ROWS[r].mask);
            poll(ROWS[r].grp, ROWS[r].bus);
            chk($sformatf("R3 row%0d onehot", r), 32'(act_onehot),
                ROWS[r].hit ? (32'h1 << ROWS[r].idx) : 32'h0);
            chk($sformatf("R1 row%0d idx", r), 32'(act_idx), 32'(ROWS[r].idx));
            step();
            chk($sformatf("R9 row%0d any_int", r), 32'(any_int), 32'(ROWS[r].hit));
        end

        // R5: replace clears earlier mask bits
        do_reset();
        wmask(24'hFFFFFE);
        wmask(24'h000001);
        poll(1'b0, 14'h0003);
        chk("R5 mask replaced", 32'(act_idx), 32'd2);

        // R6: fixed levels
        do_reset();
        sysp(3'b010);
        chk("R6 trace recorded while masked", 32'(act_idx), 32'd25);
        sysp(3'b100);
        chk("R6 trace over maint", 32'(act_idx), 32'd25);
        sysp(3'b001);
        chk("R6 check highest", 32'(act_idx), 32'd0);
        clrl(5'd0);
        chk("R11 back to trace", 32'(act_idx), 32'd25);
        clrl(5'd25);
        chk("R11 maint next", 32'(act_idx), 32'd26);

        // R7: program interrupt
        do_reset();
        prog(1'b1, 14'h2000);
        chk("R7 high bits ignored in upper group", 32'(act_onehot), 32'h0);
        prog(1'b1, 14'h0008);
        chk("R7 upper group level17", 32'(act_idx), 32'd18);
        prog(1'b0, 14'h2000);
        chk("R7 lower group level13", 32'(act_idx), 32'd14);

        // R1: device level 23 above trace, below level 0
        do_reset();
        wmask(24'h000000);
        poll(1'b1, 14'h0200);
        sysp(3'b010);
        chk("R1 level23 above trace", 32'(act_idx), 32'd24);
        prog(1'b0, 14'h0001);
        chk("R1 level0 above level23", 32'(act_idx), 32'd1);

        // R9 R10 R11 R12: service nesting
        do_reset();
        wmask(24'h000000);
        poll(1'b0, 14'h00A0);
        chk("R3 level5 active", 32'(act_idx), 32'd6);
        chk("R9 request not yet set", 32'(any_int), 32'h0);
        step();
        chk("R9 request set", 32'(any_int), 32'h1);
        clrq(5'd6);
        chk("R10 any_int dropped", 32'(any_int), 32'h0);
        chk("R10 level still active", 32'(act_idx), 32'd6);
        step(); step(); step();
        chk("R12 no second request", 32'(any_int), 32'h0);
        clrl(5'd6);
        chk("R11 next level active", 32'(act_idx), 32'd8);
        chk("R11 pending request shows", 32'(any_int), 32'h1);
        poll(1'b0, 14'h0020);
        chk("R12 new arrival active", 32'(act_idx), 32'd6);
        step();
        chk("R12 new arrival requested", 32'(any_int), 32'h1);

        // R8: global disable
        do_reset();
        wmask(24'h000000);
        disable_all = 1'b1;
        poll(1'b0, 14'h0001);
        chk("R8 hidden while disabled", 32'(act_onehot), 32'h0);
        step();
        chk("R8 no request while disabled", 32'(any_int), 32'h0);
        disable_all = 1'b0;
        #1;
        chk("R8 recorded level appears", 32'(act_idx), 32'd1);
        chk("R8 request one cycle later", 32'(any_int), 32'h0);
        step();
        chk("R8 request after enable", 32'(any_int), 32'h1);

        finish_run();
    end

endmodule